// File: doc/BRIEF.md
# Pulse Width Capture Timer

This block times events on a single external input. It can measure the high width, the low width, the period between rising edges, the period between falling edges, or the interval between any two consecutive edges. The input first passes through a two-flop synchronizer. Edges are then found on the synchronized level at the system clock rate. A 16-bit up-counter advances on an external count-tick enable, so the prescaler sits outside this block.

Software arms the timer with a start strobe and can halt it at any time with a stop strobe. In one-shot operation the counter is itself the result: a read shows the count while measuring and the final count afterwards. In continuous operation each completed count is copied into a buffer. A read then shows only the last completed measurement. An error flag marks a result that was overwritten before anyone read it. The end-of-measurement flag and the overflow flag each drive an interrupt request through their own enable input.

Top module: `pwc_timer`

## Requirements
- R1: A start strobe in the idle state clears the counter to 0 and moves to waiting. No counting happens until the selected start edge is seen. After reset the result reads 0 and all flags are 0.
- R2: A start edge loads the counter with 1. After that, the counter advances by one only on clock cycles where `tick_en` is 1. An input change is acted on at the third rising clock edge after it is sampled. When ticks are present every cycle, the result equals the number of clock cycles between the two input changes.
- R3: The `edge_mode` field selects the start and end edges. 0 = rise to fall. 1 = rise to rise. 2 = fall to fall. 3 = any edge to any edge. 4 = fall to rise. Codes 5 to 7 produce no start edge and no end edge.
- R4: One-shot operation (`continuous`=0): `result` shows the live count while measuring. The block goes idle at the first end edge and `result` then holds the final count.
- R5: Continuous operation (`continuous`=1): the count is copied into a buffer at every end edge, and `result` shows that buffer. The buffer keeps its value while the next measurement is running.
- R6: In continuous operation with modes 1, 2 and 3, the end edge also starts the next measurement, with the counter reloaded to 1.
- R7: A buffer write while `end_flag` is still set, with no read in the same cycle, sets `err_flag`. A read (`rd_strobe`) clears both `end_flag` and `err_flag`. A flag that is being set in the same cycle as a read stays set.
- R8: A start strobe while waiting for the start edge leaves the block waiting. A start strobe while measuring clears the counter to 0 and returns the block to waiting.
- R9: If an end edge and a start strobe fall in the same cycle, `end_flag` is still set. In continuous operation the count is still buffered, and the block then waits for a start edge.
- R10: When the counter rolls over from 0xFFFF while measuring, `ovf_flag` is set and the counter wraps to 0. One-shot operation then goes idle. A start strobe clears `ovf_flag`.
- R11: `end_irq` is high exactly when `end_flag` and `end_ie` are both 1. `ovf_irq` is high exactly when `ovf_flag` and `ovf_ie` are both 1.
- R12: A stop strobe sends the block to idle from any state on the next clock edge, and the count is frozen. The stop strobe wins over a start strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pulse_in | input | 1 | Asynchronous signal being measured |
| start_strobe | input | 1 | One-cycle start/restart command |
| stop_strobe | input | 1 | One-cycle forced stop command |
| edge_mode | input | 3 | Measurement edge pair selector |
| continuous | input | 1 | 1 = continuous with buffer, 0 = one-shot |
| tick_en | input | 1 | Count-clock tick enable |
| rd_strobe | input | 1 | Result read; clears end and error flags |
| end_ie | input | 1 | End-of-measurement interrupt enable |
| ovf_ie | input | 1 | Overflow interrupt enable |
| result | output | 16 | Live count (one-shot) or buffered result (continuous) |
| end_flag | output | 1 | Measurement completed |
| ovf_flag | output | 1 | Counter overflow occurred |
| err_flag | output | 1 | Unread result was overwritten |
| end_irq | output | 1 | End-of-measurement interrupt request |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
The bench targets the cycle where an end edge and a restart coincide. A design that let the restart win there would lose the result and leave `end_flag` clear. It also checks that the cycle modes share the end edge as the next start edge: a design that waited for a fresh start edge would report only part of the second period. A one-cycle pulse, a counter left without ticks, the full 16-bit rollover and an illegal edge code cover the remaining off-by-one, gating and decode faults. Overwrite-before-read and read-after-set sequences expose an error flag that is set or cleared in the wrong cycle.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_WAIT = 2'd1,
        S_MEAS = 2'd2
    } pwc_state_t;

    localparam logic [2:0] EM_HIGH = 3'd0;
    localparam logic [2:0] EM_RISE = 3'd1;
    localparam logic [2:0] EM_FALL = 3'd2;
    localparam logic [2:0] EM_ANY  = 3'd3;
    localparam logic [2:0] EM_LOW  = 3'd4;

endpackage

// File: rtl/pwc_edge_sync.sv
module pwc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    localparam int LAST = STAGES;

    logic [LAST:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[LAST-1:0], din};
    end

    // chain[LAST-1] is the settled level, chain[LAST] the level one cycle older
    always_comb begin
        rise = chain[LAST-1] & ~chain[LAST];
        fall = ~chain[LAST-1] & chain[LAST];
    end
endmodule

// File: rtl/pwc_edge_sel.sv
module pwc_edge_sel
    import pwc_pkg::*;
(
    input  logic [2:0] mode,
    input  logic       rise,
    input  logic       fall,
    output logic       start_edge,
    output logic       end_edge,
    output logic       shared,
    output logic       mode_legal
);
    always_comb begin
        start_edge = 1'b0;
        end_edge   = 1'b0;
        shared     = 1'b0;
        mode_legal = 1'b1;
        unique case (mode)
            EM_HIGH: begin start_edge = rise;        end_edge = fall;        end
            EM_RISE: begin start_edge = rise;        end_edge = rise;        shared = 1'b1; end
            EM_FALL: begin start_edge = fall;        end_edge = fall;        shared = 1'b1; end
            EM_ANY:  begin start_edge = rise | fall; end_edge = rise | fall; shared = 1'b1; end
            EM_LOW:  begin start_edge = fall;        end_edge = rise;        end
            default: mode_legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwc_flags.sv
module pwc_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic end_set,
    input  logic buf_wr,
    input  logic ovf_set,
    input  logic ovf_clr,
    input  logic rd,
    input  logic end_ie,
    input  logic ovf_ie,
    output logic end_flag,
    output logic ovf_flag,
    output logic err_flag,
    output logic end_irq,
    output logic ovf_irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            end_flag <= 1'b0;
            ovf_flag <= 1'b0;
            err_flag <= 1'b0;
        end else begin
            if (end_set)  end_flag <= 1'b1;
            else if (rd)  end_flag <= 1'b0;

            if (buf_wr && end_flag && !rd) err_flag <= 1'b1;
            else if (rd)                   err_flag <= 1'b0;

            if (ovf_set)      ovf_flag <= 1'b1;
            else if (ovf_clr) ovf_flag <= 1'b0;
        end
    end

    always_comb begin
        end_irq = end_flag & end_ie;
        ovf_irq = ovf_flag & ovf_ie;
    end
endmodule

// File: rtl/pwc_timer.sv
module pwc_timer
    import pwc_pkg::*;
#(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pulse_in,
    input  logic         start_strobe,
    input  logic         stop_strobe,
    input  logic [2:0]   edge_mode,
    input  logic         continuous,
    input  logic         tick_en,
    input  logic         rd_strobe,
    input  logic         end_ie,
    input  logic         ovf_ie,
    output logic [W-1:0] result,
    output logic         end_flag,
    output logic         ovf_flag,
    output logic         err_flag,
    output logic         end_irq,
    output logic         ovf_irq
);
    localparam logic [W-1:0] CNT_MAX = '1;
    localparam logic [W-1:0] CNT_ONE = W'(1);

    logic       rise, fall;
    logic       start_edge, end_edge, shared, mode_legal;
    pwc_state_t state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d, buf_q;
    logic       end_set, buf_wr, ovf_set;

    pwc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst_n(rst_n),
        .din (pulse_in),
        .rise(rise),
        .fall(fall)
    );

    pwc_edge_sel u_sel (
        .mode      (edge_mode),
        .rise      (rise),
        .fall      (fall),
        .start_edge(start_edge),
        .end_edge  (end_edge),
        .shared    (shared),
        .mode_legal(mode_legal)
    );

    // next-state and counter decisions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        end_set = 1'b0;
        buf_wr  = 1'b0;
        ovf_set = 1'b0;
        if (stop_strobe) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start_strobe) begin
                        state_d = S_WAIT;
                        cnt_d   = '0;
                    end
                end
                S_WAIT: begin
                    if (start_edge) begin
                        state_d = S_MEAS;
                        cnt_d   = CNT_ONE;
                    end else if (start_strobe) begin
                        cnt_d = '0;
                    end
                end
                S_MEAS: begin
                    if (end_edge) begin
                        end_set = 1'b1;
                        buf_wr  = continuous;
                        if (start_strobe) begin
                            state_d = S_WAIT;
                            cnt_d   = '0;
                        end else if (continuous && shared) begin
                            cnt_d = CNT_ONE;
                        end else if (continuous) begin
                            state_d = S_WAIT;
                        end else begin
                            state_d = S_IDLE;
                        end
                    end else if (start_strobe) begin
                        state_d = S_WAIT;
                        cnt_d   = '0;
                    end else if (tick_en) begin
                        if (cnt_q == CNT_MAX) begin
                            ovf_set = 1'b1;
                            cnt_d   = '0;
                            if (!continuous) state_d = S_IDLE;
                        end else begin
                            cnt_d = cnt_q + CNT_ONE;
                        end
                    end
                end
                default: state_d = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            buf_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            if (buf_wr) buf_q <= cnt_q;
        end
    end

    always_comb result = continuous ? buf_q : cnt_q;

    pwc_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .end_set (end_set),
        .buf_wr  (buf_wr),
        .ovf_set (ovf_set),
        .ovf_clr (start_strobe & ~stop_strobe),
        .rd      (rd_strobe),
        .end_ie  (end_ie),
        .ovf_ie  (ovf_ie),
        .end_flag(end_flag),
        .ovf_flag(ovf_flag),
        .err_flag(err_flag),
        .end_irq (end_irq),
        .ovf_irq (ovf_irq)
    );
endmodule

// File: rtl/pwc_timer_chk.sv
module pwc_timer_chk
    import pwc_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_strobe,
    input logic         stop_strobe,
    input logic         continuous,
    input logic         tick_en,
    input logic         rd_strobe,
    input logic         end_flag,
    input logic         ovf_flag,
    input logic         err_flag,
    input pwc_state_t   state_q,
    input logic [W-1:0] cnt_q,
    input logic [W-1:0] buf_q,
    input logic         start_edge,
    input logic         end_edge,
    input logic         mode_legal
);
    assert_stop_idles_R12: assert property (@(posedge clk) disable iff (!rst_n)
        stop_strobe |=> state_q == S_IDLE);

    assert_start_arms_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_strobe && !stop_strobe && state_q == S_IDLE) |=> (state_q == S_WAIT && cnt_q == '0));

    assert_read_clears_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> !err_flag);

    assert_err_with_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> end_flag);

    assert_no_overflow_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_MEAS && (&cnt_q) && tick_en && !end_edge && !start_strobe && !stop_strobe)
        |=> ovf_flag);

    assert_idle_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !start_strobe) |=> $stable(cnt_q));

    assert_wait_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT && !start_edge && !stop_strobe) |=> state_q == S_WAIT);

    assert_illegal_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_legal |-> (!start_edge && !end_edge));

    assert_end_buffers_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_MEAS && end_edge && continuous && !stop_strobe)
        |=> (buf_q == $past(cnt_q) && end_flag));
endmodule

bind pwc_timer pwc_timer_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_strobe(start_strobe),
    .stop_strobe (stop_strobe),
    .continuous  (continuous),
    .tick_en     (tick_en),
    .rd_strobe   (rd_strobe),
    .end_flag    (end_flag),
    .ovf_flag    (ovf_flag),
    .err_flag    (err_flag),
    .state_q     (state_q),
    .cnt_q       (cnt_q),
    .buf_q       (buf_q),
    .start_edge  (start_edge),
    .end_edge    (end_edge),
    .mode_legal  (mode_legal)
);

// File: tb/sim_pwc_timer.sv
module sim_pwc_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pulse_in = 1'b0;
    logic        start_strobe = 1'b0;
    logic        stop_strobe = 1'b0;
    logic [2:0]  edge_mode = 3'd0;
    logic        continuous = 1'b0;
    logic        tick_en = 1'b1;
    logic        rd_strobe = 1'b0;
    logic        end_ie = 1'b1;
    logic        ovf_ie = 1'b1;
    logic [15:0] result;
    logic        end_flag, ovf_flag, err_flag, end_irq, ovf_irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwc_timer u0 (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in),
        .start_strobe(start_strobe), .stop_strobe(stop_strobe),
        .edge_mode(edge_mode), .continuous(continuous), .tick_en(tick_en),
        .rd_strobe(rd_strobe), .end_ie(end_ie), .ovf_ie(ovf_ie),
        .result(result), .end_flag(end_flag), .ovf_flag(ovf_flag),
        .err_flag(err_flag), .end_irq(end_irq), .ovf_irq(ovf_irq)
    );

    // [35:33] mode, [32] idle level, [31:24] gap1, [23:16] gap2 (0 = none), [15:0] expected
    localparam int NV = 7;
    localparam logic [35:0] VECS [NV] = '{
        {3'd0, 1'b0, 8'd5, 8'd0, 16'd5},
        {3'd4, 1'b1, 8'd7, 8'd0, 16'd7},
        {3'd1, 1'b0, 8'd3, 8'd4, 16'd7},
        {3'd2, 1'b1, 8'd6, 8'd2, 16'd8},
        {3'd3, 1'b0, 8'd9, 8'd0, 16'd9},
        {3'd3, 1'b1, 8'd4, 8'd0, 16'd4},
        {3'd0, 1'b0, 8'd1, 8'd0, 16'd1}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_cmd();
        start_strobe = 1'b1; cyc(1); start_strobe = 1'b0;
    endtask

    task automatic read_cmd();
        rd_strobe = 1'b1; cyc(1); rd_strobe = 1'b0;
    endtask

    task automatic flip(input int n);
        pulse_in = ~pulse_in; cyc(n);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        // R1: reset state
        chk("R1 reset result", result, 0);
        chk("R1 reset flags", {end_flag, ovf_flag, err_flag, end_irq, ovf_irq}, 0);

        // table walk: one-shot measurements (R2, R3, R4, R11)
        for (int i = 0; i < NV; i++) begin
            edge_mode = VECS[i][35:33];
            continuous = 1'b0;
            pulse_in = VECS[i][32];
            cyc(4);
            start_cmd();
            cyc(2);
            flip(VECS[i][31:24]);
            if (VECS[i][23:16] != 0) flip(VECS[i][23:16]);
            pulse_in = ~pulse_in;
            cyc(5);
            chk("R2 R3 table result", result, VECS[i][15:0]);
            chk("R4 table end_flag", end_flag, 1);
            chk("R11 table end_irq", end_irq, 1);
            read_cmd();
            chk("R7 read clears end", end_flag, 0);
        end

        // R11: interrupt masked
        edge_mode = 3'd0; pulse_in = 1'b0; cyc(4);
        start_cmd(); cyc(2); flip(3); pulse_in = 1'b0; cyc(5);
        end_ie = 1'b0; cyc(1);
        chk("R11 masked end_irq", end_irq, 0);
        chk("R11 flag kept", end_flag, 1);
        end_ie = 1'b1; read_cmd();

        // R4 live count and R8 restart during measurement
        start_cmd(); cyc(2);
        flip(4);
        chk("R4 live count", result, 2);
        start_cmd(); cyc(2);
        chk("R8 restart clears", result, 0);
        flip(5);
        chk("R8 no end after restart", end_flag, 0);
        start_cmd();   // restart while waiting: no effect
        cyc(2);
        flip(4); flip(5);
        chk("R8 measure after restart", result, 4);
        read_cmd();

        // R2: no ticks, count stays at 1
        tick_en = 1'b0;
        start_cmd(); cyc(2);
        flip(6); flip(5);
        chk("R2 no tick result", result, 1);
        tick_en = 1'b1; read_cmd();

        // R12: forced stop
        start_cmd(); cyc(2);
        flip(4);
        stop_strobe = 1'b1; cyc(1); stop_strobe = 1'b0;
        cyc(3);
        chk("R12 frozen count", result, 2);
        flip(5);
        chk("R12 no end after stop", end_flag, 0);
        chk("R12 count still frozen", result, 2);
        // R12: stop wins over start
        start_strobe = 1'b1; stop_strobe = 1'b1; cyc(1);
        start_strobe = 1'b0; stop_strobe = 1'b0; cyc(2);
        flip(4); flip(5);
        chk("R12 stop beats start", end_flag, 0);

        // R3: illegal code
        edge_mode = 3'd5; start_cmd(); cyc(2);
        flip(3); flip(3); flip(5);
        chk("R3 illegal no end", end_flag, 0);
        chk("R3 illegal result", result, 0);
        stop_strobe = 1'b1; cyc(1); stop_strobe = 1'b0;

        // R5, R7: continuous high width with overwrite
        edge_mode = 3'd0; continuous = 1'b1; pulse_in = 1'b0; cyc(4);
        start_cmd(); cyc(2);
        flip(4); flip(5);
        chk("R5 first buffered", result, 4);
        chk("R7 no error yet", err_flag, 0);
        flip(3);
        chk("R5 buffer retained", result, 4);
        cyc(3); flip(5);
        chk("R5 second buffered", result, 6);
        chk("R7 overwrite error", err_flag, 1);
        read_cmd();
        chk("R7 read clears err", err_flag, 0);
        chk("R7 read clears end", end_flag, 0);

        // R6: shared edge, rise to rise
        stop_strobe = 1'b1; cyc(1); stop_strobe = 1'b0;
        edge_mode = 3'd1; pulse_in = 1'b0; cyc(4);
        start_cmd(); cyc(2);
        flip(2); flip(3);
        pulse_in = 1'b1; cyc(4);
        chk("R6 first period", result, 5);
        read_cmd();
        flip(2); pulse_in = 1'b1; cyc(5);
        chk("R6 shared period", result, 7);
        chk("R7 no error after read", err_flag, 0);
        read_cmd();

        // R9: end edge and restart together
        stop_strobe = 1'b1; cyc(1); stop_strobe = 1'b0;
        edge_mode = 3'd0; pulse_in = 1'b0; cyc(4);
        start_cmd(); cyc(2);
        flip(5);
        pulse_in = 1'b0; cyc(2);
        start_cmd(); cyc(3);
        chk("R9 end flag kept", end_flag, 1);
        chk("R9 result buffered", result, 5);
        flip(3); flip(5);
        chk("R9 waits then measures", result, 3);
        read_cmd();
        stop_strobe = 1'b1; cyc(1); stop_strobe = 1'b0;

        // R10: overflow in one-shot
        continuous = 1'b0; pulse_in = 1'b0; cyc(4);
        start_cmd(); cyc(2);
        flip(65540);
        chk("R10 overflow flag", ovf_flag, 1);
        chk("R11 overflow irq", ovf_irq, 1);
        chk("R10 wrapped count", result, 0);
        flip(5);
        chk("R10 stopped no end", end_flag, 0);
        ovf_ie = 1'b0; cyc(1);
        chk("R11 masked ovf_irq", ovf_irq, 0);
        start_cmd();
        chk("R10 start clears ovf", ovf_flag, 0);

        done = 1'b1;
        finish_run();
    end
endmodule